// File: doc/BRIEF.md
# Saturating Cache Hit/Miss Monitors

This block keeps four performance counters for a data cache: read hits, read misses, write hits and write misses. The cache pipeline presents at most one classified access per clock. The access carries a direction and two hit indications: one from the tag lookup and one from the refill buffer, which holds a line still being fetched for an earlier miss. The block sorts that access into exactly one of the four categories and advances the matching counter.

A control register outside the block gives each counter its own enable bit and its own clear bit. A disabled counter holds its value. A counter whose clear bit is set stays at zero until software drops the bit. Hit counters are wider than miss counters, and every counter stops at its all-ones value instead of wrapping. Software reads the counters through a plain registered read port at fixed byte offsets.

Top module: `cache_perf_mon`

## Requirements
- R1: After rst_ni is released, all four counters read zero and rd_valid_o is low.
- R2: A valid access with acc_write_i=0 and tag_hit_i or refill_hit_i high counts as a read hit. The same access with acc_write_i=1 counts as a write hit. Counter index 0 is read-hit and index 2 is write-hit.
- R3: A valid access counts as a miss only when tag_hit_i and refill_hit_i are both low. It goes to index 1 (read-miss) when acc_write_i=0, or to index 3 (write-miss) when acc_write_i=1.
- R4: The hit counters are HIT_W=32 bits wide and the miss counters are MISS_W=16 bits wide. Bits above a miss counter's width read as zero.
- R5: A counter at its all-ones value stays there when further events arrive.
- R6: While mon_en_i[i] is 0, counter i ignores events and keeps its value. Counting resumes from that value once the bit returns to 1.
- R7: While mon_clr_i[i] is 1, counter i is held at zero. Counting resumes only after the bit returns to 0.
- R8: When mon_clr_i[i] is 1 in the same cycle as an event for counter i, the counter ends the cycle at zero.
- R9: A read with rd_en_i high returns data one cycle later, marked by rd_valid_o. The data is the counter value before that clock edge. Byte offsets are 0x10 read-hit, 0x14 read-miss, 0x20 write-hit and 0x24 write-miss. Any other offset reads zero.
- R10: An access with acc_valid_i low counts nothing. A valid access advances exactly one counter by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | One-cycle pulse: a cacheable access was looked up |
| acc_write_i | input | 1 | Access direction, 1 = write |
| tag_hit_i | input | 1 | Line found valid in the tag memory |
| refill_hit_i | input | 1 | Line found in flight in the refill buffer |
| mon_en_i | input | 4 | Per-counter enable, index order RH, RM, WH, WM |
| mon_clr_i | input | 4 | Per-counter clear/hold, same index order |
| rd_en_i | input | 1 | Register read request |
| rd_addr_i | input | ADDR_W (6) | Read byte offset |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| rd_data_o | output | 32 | Read data, zero-extended |

## Verification
Two things can land on the same counter in the same cycle: a clear held by software and a counted event. The bench raises one clear bit and presents a matching access in that same cycle. It then reads the counter and expects zero. It also holds a clear bit across several matching events and expects zero on a read taken while the bit is still high. A read issued in the same cycle as an event is also judged: it must return the value from before that edge, and a second read must show the increment.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int unsigned NUM_MON = 4;

  typedef enum logic [1:0] {
    MON_RD_HIT  = 2'd0,
    MON_RD_MISS = 2'd1,
    MON_WR_HIT  = 2'd2,
    MON_WR_MISS = 2'd3
  } mon_sel_e;

  // index bit1 = write, bit0 = miss
  function automatic logic [7:0] mon_offset(input int unsigned idx);
    logic [7:0] off;
    off = 8'h10;
    if ((idx & 2) != 0) off = off + 8'h10;
    if ((idx & 1) != 0) off = off + 8'h04;
    return off;
  endfunction

  function automatic bit mon_is_hit(input int unsigned idx);
    return (idx & 1) == 0;
  endfunction
endpackage

// File: rtl/mon_event_decode.sv
module mon_event_decode
  import perf_mon_pkg::*;
(
  input  logic               acc_valid_i,
  input  logic               acc_write_i,
  input  logic               tag_hit_i,
  input  logic               refill_hit_i,
  output logic [NUM_MON-1:0] evt_o
);
  logic     any_hit;
  mon_sel_e sel;

  always_comb begin
    any_hit = tag_hit_i | refill_hit_i;
    sel     = mon_sel_e'({acc_write_i, ~any_hit});
    evt_o   = '0;
    if (acc_valid_i) evt_o[sel] = 1'b1;
  end
endmodule

// File: rtl/mon_sat_counter.sv
module mon_sat_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             evt_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic [WIDTH-1:0] cnt_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (en_i && evt_i && !at_max)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);

  assert_clear_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && en_i && evt_i) |=> cnt_o == '0);

  assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);

  assert_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(cnt_o));

  assert_step_one_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && evt_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/mon_read_port.sv
module mon_read_port
  import perf_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            rd_en_i,
  input  logic [ADDR_W-1:0]               rd_addr_i,
  input  logic [NUM_MON-1:0][DATA_W-1:0]  cnt_i,
  output logic                            rd_valid_o,
  output logic [DATA_W-1:0]               rd_data_o
);
  logic [NUM_MON-1:0] match;
  logic [DATA_W-1:0]  sel_data;
  logic               valid_q;
  logic [DATA_W-1:0]  data_q;

  for (genvar g = 0; g < NUM_MON; g++) begin : g_dec
    assign match[g] = (rd_addr_i == ADDR_W'(mon_offset(g)));
  end

  always_comb begin
    sel_data = '0;
    for (int i = 0; i < NUM_MON; i++)
      if (match[i]) sel_data = sel_data | cnt_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_en_i;
      data_q  <= rd_en_i ? sel_data : '0;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;

  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && match == '0) |=> rd_data_o == '0);

  assert_single_decode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/cache_perf_mon.sv
module cache_perf_mon
  import perf_mon_pkg::*;
#(
  parameter int unsigned HIT_W  = 32,
  parameter int unsigned MISS_W = 16,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned DATA_W = (HIT_W > MISS_W) ? HIT_W : MISS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic               acc_write_i,
  input  logic               tag_hit_i,
  input  logic               refill_hit_i,
  input  logic [NUM_MON-1:0] mon_en_i,
  input  logic [NUM_MON-1:0] mon_clr_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic               rd_valid_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic [NUM_MON-1:0]             evt;
  logic [NUM_MON-1:0][DATA_W-1:0] cnt_ext;

  mon_event_decode u_dec (
    .acc_valid_i  (acc_valid_i),
    .acc_write_i  (acc_write_i),
    .tag_hit_i    (tag_hit_i),
    .refill_hit_i (refill_hit_i),
    .evt_o        (evt)
  );

  assert_one_event_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |-> $countones(evt) == 1);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> evt == '0);

  assert_miss_needs_no_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt[MON_RD_MISS] || evt[MON_WR_MISS]) |-> !(tag_hit_i || refill_hit_i));

  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    localparam int unsigned W = mon_is_hit(g) ? HIT_W : MISS_W;
    logic [W-1:0] cnt;

    mon_sat_counter #(.WIDTH(W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (mon_en_i[g]),
      .clr_i  (mon_clr_i[g]),
      .evt_i  (evt[g]),
      .cnt_o  (cnt)
    );

    assign cnt_ext[g] = DATA_W'(cnt);
  end

  mon_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .cnt_i      (cnt_ext),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: tb/sim_cache_perf_mon.sv
module sim_cache_perf_mon;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              acc_valid = 1'b0, acc_write = 1'b0, tag_hit = 1'b0, refill_hit = 1'b0;
  logic [3:0]        mon_en = '0, mon_clr = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;

  cache_perf_mon u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .tag_hit_i(tag_hit), .refill_hit_i(refill_hit),
    .mon_en_i(mon_en), .mon_clr_i(mon_clr),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];
  longint unsigned   model[4];

  function automatic longint unsigned cap(int i);
    return (i % 2 == 0) ? 64'hFFFF_FFFF : 64'hFFFF;
  endfunction

  function automatic int addr_idx(logic [ADDR_W-1:0] a);
    case (a)
      6'h10: return 0;
      6'h14: return 1;
      6'h20: return 2;
      6'h24: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // one clock with an optional access; reference model follows the requirements
  task automatic tick(input logic v, input logic w, input logic th, input logic rh);
    int idx;
    acc_valid = v; acc_write = w; tag_hit = th; refill_hit = rh;
    idx = {w, ~(th | rh)};
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      if (mon_clr[i]) model[i] = 0;
      else if (v && idx == i && mon_en[i] && model[i] < cap(i)) model[i]++;
    end
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; tag_hit = 1'b0; refill_hit = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag,
                    input logic v = 0, input logic w = 0, input logic th = 0, input logic rh = 0);
    int k;
    k = addr_idx(a);
    exp_q.push_back(k < 0 ? '0 : DATA_W'(model[k]));
    tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = a;
    tick(v, w, th, rh);
    rd_en = 1'b0;
  endtask

  task automatic rd_all(input string tag);
    rd(6'h10, tag); rd(6'h14, tag); rd(6'h20, tag); rd(6'h24, tag);
  endtask

  task automatic repeat_acc(input int n, input logic w, input logic th, input logic rh);
    for (int i = 0; i < n; i++) tick(1'b1, w, th, rh);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid && !done) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9 unexpected rd_valid got=%0h exp=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got=running exp=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_valid after reset", {31'b0, rd_valid}, 32'd0);
    rd_all("R1 reset value");

    // disabled monitors ignore traffic (R6)
    repeat_acc(3, 0, 1, 0);
    repeat_acc(2, 1, 0, 0);
    rd_all("R6 disabled after reset");

    mon_en = 4'hF;
    repeat_acc(3, 0, 1, 0);          // R2 tag hit read
    repeat_acc(2, 0, 0, 1);          // R2 refill-buffer hit read
    repeat_acc(1, 0, 1, 1);
    repeat_acc(4, 0, 0, 0);          // R3 read miss
    repeat_acc(1, 1, 1, 0);          // R2 write hit
    repeat_acc(2, 1, 0, 1);
    repeat_acc(3, 1, 0, 0);          // R3 write miss
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1'b1, 1'b1);  // R10 invalid
    rd(6'h10, "R2 read hit");
    rd(6'h14, "R3 read miss");
    rd(6'h20, "R2 write hit");
    rd(6'h24, "R3 write miss");
    rd_all("R10 single count per access");

    // freeze and resume (R6)
    mon_en[0] = 1'b0;
    repeat_acc(5, 0, 1, 0);
    rd(6'h10, "R6 frozen");
    mon_en[0] = 1'b1;
    repeat_acc(1, 0, 1, 0);
    rd(6'h10, "R6 resumed");

    // held clear (R7)
    mon_clr[1] = 1'b1;
    repeat_acc(3, 0, 0, 0);
    rd(6'h14, "R7 held at zero");
    mon_clr[1] = 1'b0;
    repeat_acc(2, 0, 0, 0);
    rd(6'h14, "R7 resumes after release");

    // clear and event in the same cycle (R8)
    mon_clr[2] = 1'b1;
    tick(1'b1, 1'b1, 1'b1, 1'b0);
    mon_clr[2] = 1'b0;
    rd(6'h20, "R8 clear wins");
    rd(6'h24, "R8 neighbour untouched");

    // read in the same cycle as an event sees the pre-edge value (R9)
    rd(6'h24, "R9 read with event", 1'b1, 1'b1, 1'b0, 1'b0);
    rd(6'h24, "R9 after event");
    rd(6'h18, "R9 unmapped");
    rd(6'h00, "R9 unmapped");
    rd(6'h3C, "R9 unmapped");

    // miss counter saturation (R5, R4)
    repeat_acc(65540, 0, 0, 0);
    rd(6'h14, "R5 read miss saturated");
    repeat_acc(3, 0, 0, 0);
    rd(6'h14, "R4 miss upper bits zero");

    // hit counter exceeds 16 bits (R4)
    repeat_acc(65540, 0, 1, 0);
    rd(6'h10, "R4 hit counter wider");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R9 missing reads got=%0d exp=0", exp_q.size());
    end
    finish_run();
  end
endmodule